// File: doc/BRIEF.md
# Clock-Group Stop and Power-Down Controller

This block sits between the clock dividers and the output pads of a system clock generator. It receives already-divided clocks for the processor, peripheral-bus and graphics-port groups, plus the reference, 48 MHz and memory clocks. It drives gated copies of each one. A gated output is held low whenever its group is stopped. The stop decisions come from active-low request pins that are asynchronous to every clock they control. Each request is synchronized in the domain of its target clock. The enable only changes while that clock is low, so the clock is cut and restored only on whole cycles.

A mode strap and three frequency-select straps are captured while power-on reset is held low and are frozen afterwards. In mobile mode (strap 0), four shared pins act as inputs: processor stop, peripheral stop, graphics stop and power-down. In desktop mode (strap 1), the same four pins turn into outputs that carry the memory clock, and every stop and power-down function is inactive.

Power-down takes precedence over every individual stop. First all gated outputs are closed, including the free-running ones. Once every gate is seen closed, the VCO enable is dropped, and the oscillator enable follows one reference cycle later. On release, the oscillator enable returns first, the VCO enable follows, and the clocks then reopen.

Top module: `clkgrp_stop_ctrl`

## Requirements
- R1: `mode_q` and `fsel_q` take the values of `strap_mode` and `strap_fsel` present while `por_n` is low. After `por_n` rises they keep those values whatever the strap pins do.
- R2: With the mode strap at 0, `shared_oe` and `shared_out` are all zero. With it at 1, `shared_oe` is all ones and every `shared_out` bit toggles with the memory clock. `shared_oe` is zero while `por_n` is low.
- R3: In mode 0, `shared_in[0]` low holds every `cpu_clk_o` bit low. Releasing it makes them toggle again.
- R4: In mode 0, `shared_in[1]` low holds every `pci_clk_o` bit low, while `pci_free_o` keeps toggling.
- R5: In mode 0, `shared_in[2]` low holds every `agp_clk_o` bit low, while `agp_free_o` keeps toggling.
- R6: While `shared_in[3]` is high, `ref_o`, `usb_o` and `mem_clk_o` toggle and `osc_en` and `vco_en` stay 1, for any level of `shared_in[2:0]`.
- R7: In mode 0, `shared_in[3]` low drives every clock output low, including `pci_free_o`, `agp_free_o`, `ref_o`, `usb_o` and `mem_clk_o`. It then clears `vco_en` and `osc_en`. `osc_en` is never 0 while `vco_en` is 1, nor while any clock output is high.
- R8: Raising `shared_in[3]` again sets `osc_en` first and `vco_en` after it, and all unstopped clocks resume.
- R9: In mode 1, no level on `shared_in` stops any clock or clears `osc_en` or `vco_en`.
- R10: Outside reset, no gated output ever shows a high pulse shorter than the high phase of its source clock.
- R11: While power-down is asserted, releasing the individual stop pins leaves every clock output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on reset, active low; straps are captured while low |
| clk_ref | input | 1 | Reference clock; also clocks the strap latch and power sequencer |
| clk_cpu | input | 1 | Divided processor clock |
| clk_pci | input | 1 | Divided peripheral-bus clock |
| clk_agp | input | 1 | Divided graphics-port clock |
| clk_usb | input | 1 | 48 MHz clock |
| clk_mem | input | 1 | Memory clock |
| strap_mode | input | 1 | Mode strap: 0 mobile, 1 desktop |
| strap_fsel | input | 3 | Frequency-select straps |
| shared_in | input | 4 | Shared pin levels: [0] cpu stop, [1] pci stop, [2] agp stop, [3] power-down, all active low |
| shared_out | output | 4 | Memory clock copies driven onto the shared pins in desktop mode |
| shared_oe | output | 4 | Output enables of the shared pins |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| pci_clk_o | output | N_PCI | Stoppable peripheral-bus clocks |
| pci_free_o | output | 1 | Free-running peripheral-bus clock |
| agp_clk_o | output | N_AGP | Stoppable graphics-port clocks |
| agp_free_o | output | 1 | Free-running graphics-port clock |
| ref_o | output | 1 | Gated reference clock |
| usb_o | output | 1 | Gated 48 MHz clock |
| mem_clk_o | output | N_MEM | Gated dedicated memory clocks |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| mode_q | output | 1 | Latched mode strap |
| fsel_q | output | 3 | Latched frequency-select straps |

## Verification
Errors in the synchronizer or enable flops show up at the gated outputs within a few cycles of the source clock. The symptom is a group that fails to stop or restart, or a high pulse cut shorter than the source high phase. An error in the power sequencer shows up in `osc_en`/`vco_en` within roughly twenty reference cycles of a power-down edge: they drop while a clock still toggles, rise in the wrong order, or never return. A strap latch that keeps sampling after reset changes `mode_q`/`fsel_q` on the next reference edge after the strap pins move. A strap latch that samples the wrong pins flips the shared pins between input and output.

// File: rtl/clkgrp_pkg.sv
package clkgrp_pkg;

    // gate slots, one per source clock / stop condition
    localparam int unsigned NUM_GATES  = 8;
    localparam int unsigned G_CPU      = 0;
    localparam int unsigned G_PCI      = 1;
    localparam int unsigned G_PCIF     = 2;
    localparam int unsigned G_AGP      = 3;
    localparam int unsigned G_AGPF     = 4;
    localparam int unsigned G_REF      = 5;
    localparam int unsigned G_USB      = 6;
    localparam int unsigned G_MEM      = 7;

    // shared pin roles (mobile mode)
    localparam int unsigned NUM_SHARED  = 4;
    localparam int unsigned SH_CPU_STOP = 0;
    localparam int unsigned SH_PCI_STOP = 1;
    localparam int unsigned SH_AGP_STOP = 2;
    localparam int unsigned SH_PWR_DOWN = 3;

    localparam int unsigned FSEL_W = 3;

    typedef struct packed {
        logic              mode;
        logic [FSEL_W-1:0] fsel;
    } strap_t;

endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import clkgrp_pkg::*;
(
    input  logic   clk_i,
    input  logic   por_n_i,
    input  strap_t pins_i,
    output strap_t strap_o
);
    strap_t strap_d, strap_q;

    // follow the pins while reset is held, freeze once it is released
    always_comb begin
        strap_d = strap_q;
        if (!por_n_i) begin
            strap_d = pins_i;
        end
    end

    always_ff @(posedge clk_i) begin
        strap_q <= strap_d;
    end

    assign strap_o = strap_q;
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic stop_req_i,
    output logic clk_o,
    output logic open_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     en_d, en_q;

    always_comb begin
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], stop_req_i};
        en_d      = ~st_q.sync[SYNC_STAGES-1];
    end

    // synchronizer on the rising edge; reset leaves the gate in the stopped state
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q.sync <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // enable moves only on the falling edge, i.e. while the clock is low
    always_ff @(negedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign clk_o  = clk_i & en_q;
    assign open_o = en_q;
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq #(
    parameter int unsigned NG            = 8,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          pd_req_i,
    input  logic [NG-1:0] gate_open_i,
    output logic          run_o,
    output logic          osc_en_o,
    output logic          vco_en_o
);
    localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0]         pd_sync;
        logic [SYNC_STAGES-1:0][NG-1:0] open_sync;
        logic                           run;
        logic                           osc;
        logic                           vco;
        logic [CW-1:0]                  cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic          pd_held;
    logic [NG-1:0] open_seen;

    always_comb begin
        pd_held   = st_q.pd_sync[SYNC_STAGES-1];
        open_seen = st_q.open_sync[SYNC_STAGES-1];

        st_d           = st_q;
        st_d.pd_sync   = {st_q.pd_sync[SYNC_STAGES-2:0], pd_req_i};
        st_d.open_sync = {st_q.open_sync[SYNC_STAGES-2:0], gate_open_i};

        if (!pd_held) begin
            // wake: oscillator first, VCO one cycle later, then gates may reopen
            st_d.run = 1'b1;
            st_d.osc = 1'b1;
            st_d.vco = st_q.osc;
            st_d.cnt = '0;
        end else begin
            st_d.run = 1'b0;
            if (st_q.cnt != CW'(SETTLE_CYCLES)) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end else if (open_seen == '0) begin
                // all gates closed: VCO off, oscillator off one cycle later
                st_d.vco = 1'b0;
                st_d.osc = st_q.vco ? st_q.osc : 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q.pd_sync   <= '1;
            st_q.open_sync <= '0;
            st_q.run       <= 1'b0;
            st_q.osc       <= 1'b1;
            st_q.vco       <= 1'b1;
            st_q.cnt       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o    = st_q.run;
    assign osc_en_o = st_q.osc;
    assign vco_en_o = st_q.vco;
endmodule

// File: rtl/clkgrp_stop_ctrl.sv
module clkgrp_stop_ctrl
    import clkgrp_pkg::*;
#(
    parameter int unsigned N_CPU         = 3,
    parameter int unsigned N_PCI         = 5,
    parameter int unsigned N_AGP         = 2,
    parameter int unsigned N_MEM         = 9,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned SETTLE_CYCLES = 16
) (
    input  logic                  por_n,
    input  logic                  clk_ref,
    input  logic                  clk_cpu,
    input  logic                  clk_pci,
    input  logic                  clk_agp,
    input  logic                  clk_usb,
    input  logic                  clk_mem,
    input  logic                  strap_mode,
    input  logic [FSEL_W-1:0]     strap_fsel,
    input  logic [NUM_SHARED-1:0] shared_in,
    output logic [NUM_SHARED-1:0] shared_out,
    output logic [NUM_SHARED-1:0] shared_oe,
    output logic [N_CPU-1:0]      cpu_clk_o,
    output logic [N_PCI-1:0]      pci_clk_o,
    output logic                  pci_free_o,
    output logic [N_AGP-1:0]      agp_clk_o,
    output logic                  agp_free_o,
    output logic                  ref_o,
    output logic                  usb_o,
    output logic [N_MEM-1:0]      mem_clk_o,
    output logic                  osc_en,
    output logic                  vco_en,
    output logic                  mode_q,
    output logic [FSEL_W-1:0]     fsel_q
);
    strap_t strap_pins, strap_q;
    logic   mobile, stop_cpu, stop_pci, stop_agp, pd_req, run;
    logic [NUM_GATES-1:0] gate_clk, gate_req, gate_out, gate_open;

    assign strap_pins.mode = strap_mode;
    assign strap_pins.fsel = strap_fsel;

    strap_latch u_strap (
        .clk_i   (clk_ref),
        .por_n_i (por_n),
        .pins_i  (strap_pins),
        .strap_o (strap_q)
    );

    // shared pins only act as requests in mobile mode
    assign mobile   = ~strap_q.mode;
    assign stop_cpu = mobile & ~shared_in[SH_CPU_STOP];
    assign stop_pci = mobile & ~shared_in[SH_PCI_STOP];
    assign stop_agp = mobile & ~shared_in[SH_AGP_STOP];
    assign pd_req   = mobile & ~shared_in[SH_PWR_DOWN];

    pwr_seq #(
        .NG            (NUM_GATES),
        .SYNC_STAGES   (SYNC_STAGES),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_seq (
        .clk_i       (clk_ref),
        .rst_n_i     (por_n),
        .pd_req_i    (pd_req),
        .gate_open_i (gate_open),
        .run_o       (run),
        .osc_en_o    (osc_en),
        .vco_en_o    (vco_en)
    );

    // slot order follows G_* indices (bit 0 = G_CPU)
    assign gate_clk = {clk_mem, clk_usb, clk_ref, clk_agp, clk_agp, clk_pci, clk_pci, clk_cpu};
    assign gate_req = {~run, ~run, ~run, ~run, stop_agp | ~run, ~run,
                       stop_pci | ~run, stop_cpu | ~run};

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        clk_gate_cell #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_cell (
            .clk_i      (gate_clk[g]),
            .rst_n_i    (por_n),
            .stop_req_i (gate_req[g]),
            .clk_o      (gate_out[g]),
            .open_o     (gate_open[g])
        );
    end

    assign cpu_clk_o  = {N_CPU{gate_out[G_CPU]}};
    assign pci_clk_o  = {N_PCI{gate_out[G_PCI]}};
    assign pci_free_o = gate_out[G_PCIF];
    assign agp_clk_o  = {N_AGP{gate_out[G_AGP]}};
    assign agp_free_o = gate_out[G_AGPF];
    assign ref_o      = gate_out[G_REF];
    assign usb_o      = gate_out[G_USB];
    assign mem_clk_o  = {N_MEM{gate_out[G_MEM]}};

    assign shared_out = mobile ? '0 : {NUM_SHARED{gate_out[G_MEM]}};
    assign shared_oe  = {NUM_SHARED{strap_q.mode & por_n}};

    assign mode_q = strap_q.mode;
    assign fsel_q = strap_q.fsel;
endmodule

// File: rtl/clkgrp_stop_chk.sv
module clkgrp_stop_chk #(
    parameter int unsigned N_CPU = 3,
    parameter int unsigned N_PCI = 5,
    parameter int unsigned N_AGP = 2,
    parameter int unsigned N_MEM = 9
) (
    input logic             por_n,
    input logic             clk_ref,
    input logic             mode_q,
    input logic [2:0]       fsel_q,
    input logic [3:0]       shared_oe,
    input logic [3:0]       shared_out,
    input logic             osc_en,
    input logic             vco_en,
    input logic [N_CPU-1:0] cpu_clk_o,
    input logic [N_PCI-1:0] pci_clk_o,
    input logic             pci_free_o,
    input logic [N_AGP-1:0] agp_clk_o,
    input logic             agp_free_o,
    input logic             ref_o,
    input logic             usb_o,
    input logic [N_MEM-1:0] mem_clk_o
);
    // R1
    strap_hold_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        1'b1 |=> $stable({mode_q, fsel_q}));

    // R2
    mobile_pins_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        !mode_q |-> (shared_oe == 4'h0 && shared_out == 4'h0));

    // R2
    desktop_pins_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        mode_q |-> shared_oe == 4'hF);

    // R7
    quiet_when_off_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        !osc_en |-> (cpu_clk_o == '0 && pci_clk_o == '0 && !pci_free_o &&
                     agp_clk_o == '0 && !agp_free_o && !ref_o && !usb_o && mem_clk_o == '0));

    // R7
    vco_before_osc_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        !osc_en |-> !vco_en);

    // R8
    osc_before_vco_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        $rose(vco_en) |-> $past(osc_en));

    // R9
    desktop_awake_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
        mode_q |-> (osc_en && vco_en));
endmodule

bind clkgrp_stop_ctrl clkgrp_stop_chk #(
    .N_CPU (N_CPU),
    .N_PCI (N_PCI),
    .N_AGP (N_AGP),
    .N_MEM (N_MEM)
) i_chk (
    .por_n      (por_n),
    .clk_ref    (clk_ref),
    .mode_q     (mode_q),
    .fsel_q     (fsel_q),
    .shared_oe  (shared_oe),
    .shared_out (shared_out),
    .osc_en     (osc_en),
    .vco_en     (vco_en),
    .cpu_clk_o  (cpu_clk_o),
    .pci_clk_o  (pci_clk_o),
    .pci_free_o (pci_free_o),
    .agp_clk_o  (agp_clk_o),
    .agp_free_o (agp_free_o),
    .ref_o      (ref_o),
    .usb_o      (usb_o),
    .mem_clk_o  (mem_clk_o)
);

// File: tb/test_clkgrp_stop_ctrl.sv
`timescale 1ns/100ps
module test_clkgrp_stop_ctrl;
    localparam int NOBS = 9;

    logic       por_n = 1'b0;
    logic       clk_ref = 0, clk_cpu = 0, clk_pci = 0, clk_agp = 0, clk_usb = 0, clk_mem = 0;
    logic       strap_mode = 0;
    logic [2:0] strap_fsel = 0;
    logic [3:0] shared_in = 4'hF;
    logic [3:0] shared_out, shared_oe;
    logic [2:0] cpu_clk_o;
    logic [4:0] pci_clk_o;
    logic [1:0] agp_clk_o;
    logic [8:0] mem_clk_o;
    logic       pci_free_o, agp_free_o, ref_o, usb_o, osc_en, vco_en, mode_q;
    logic [2:0] fsel_q;

    int errors = 0;
    int checks = 0;

    // 125 MHz reference; other sources at unrelated rates
    always #4.0  clk_ref = ~clk_ref;
    always #5.0  clk_cpu = ~clk_cpu;
    always #15.0 clk_pci = ~clk_pci;
    always #7.5  clk_agp = ~clk_agp;
    always #10.5 clk_usb = ~clk_usb;
    initial begin
        #1.0;
        forever #5.0 clk_mem = ~clk_mem;
    end

    clkgrp_stop_ctrl i_clkgrp_stop_ctrl (
        .por_n(por_n), .clk_ref(clk_ref), .clk_cpu(clk_cpu), .clk_pci(clk_pci),
        .clk_agp(clk_agp), .clk_usb(clk_usb), .clk_mem(clk_mem),
        .strap_mode(strap_mode), .strap_fsel(strap_fsel), .shared_in(shared_in),
        .shared_out(shared_out), .shared_oe(shared_oe), .cpu_clk_o(cpu_clk_o),
        .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o), .agp_clk_o(agp_clk_o),
        .agp_free_o(agp_free_o), .ref_o(ref_o), .usb_o(usb_o), .mem_clk_o(mem_clk_o),
        .osc_en(osc_en), .vco_en(vco_en), .mode_q(mode_q), .fsel_q(fsel_q)
    );

    // observed outputs: 0 cpu, 1 pci, 2 pci free, 3 agp, 4 agp free, 5 ref, 6 usb, 7 mem, 8 shared
    logic [NOBS-1:0] obs;
    assign obs = {shared_out[3], mem_clk_o[8], usb_o, ref_o, agp_free_o, agp_clk_o[1],
                  pci_free_o, pci_clk_o[4], cpu_clk_o[2]};
    real HALF [NOBS] = '{5.0, 15.0, 15.0, 7.5, 7.5, 4.0, 10.5, 5.0, 5.0};

    logic clr = 1'b0;
    logic meas_on = 1'b0;
    int   cnt   [NOBS];
    int   short_cnt [NOBS];

    for (genvar i = 0; i < NOBS; i++) begin : g_mon
        realtime t_rise;
        always @(posedge obs[i] or posedge clr) begin
            if (clr) cnt[i] <= 0;
            else     cnt[i] <= cnt[i] + 1;
        end
        initial short_cnt[i] = 0;
        always @(posedge obs[i]) t_rise = $realtime;
        always @(negedge obs[i]) begin
            if (meas_on && ($realtime - t_rise) < HALF[i] - 0.2)
                short_cnt[i] = short_cnt[i] + 1;
        end
    end

    function automatic string obs_tag(int i);
        case (i)
            0: return "R3";
            1, 2: return "R4";
            3, 4: return "R5";
            5, 6, 7: return "R6";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [NOBS-1:0] exp_run(logic mode, logic [3:0] sh);
        logic mob, pd;
        logic [NOBS-1:0] r;
        mob  = ~mode;
        pd   = mob & ~sh[3];
        r[0] = ~pd & ~(mob & ~sh[0]);
        r[1] = ~pd & ~(mob & ~sh[1]);
        r[2] = ~pd;
        r[3] = ~pd & ~(mob & ~sh[2]);
        r[4] = ~pd;
        r[5] = ~pd;
        r[6] = ~pd;
        r[7] = ~pd;
        r[8] = mode;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // apply a pin pattern, let it settle, then measure toggling over a window
    task automatic run_phase(input logic [3:0] sh, input string ctx);
        logic [NOBS-1:0] e;
        logic pd;
        shared_in = sh;
        #400.3;
        clr = 1'b1; #1; clr = 1'b0;
        #400;
        e  = exp_run(mode_q, sh);
        pd = ~mode_q & ~sh[3];
        for (int i = 0; i < NOBS; i++) begin
            if (e[i])
                check(cnt[i] >= 3, {obs_tag(i), " ", ctx}, $sformatf("out%0d toggles", i), cnt[i], 3);
            else
                check(cnt[i] == 0 && obs[i] == 1'b0, {obs_tag(i), " ", ctx},
                      $sformatf("out%0d held low (edges)", i), cnt[i], 0);
        end
        check(osc_en == ~pd, {pd ? "R7 " : "R6 ", ctx}, "osc_en", osc_en, ~pd);
        check(vco_en == ~pd, {pd ? "R7 " : "R6 ", ctx}, "vco_en", vco_en, ~pd);
        check(shared_oe == {4{mode_q}}, {"R2 ", ctx}, "shared_oe", shared_oe, {4{mode_q}});
    endtask

    task automatic do_reset(input logic mode, input logic [2:0] fsel);
        meas_on    = 1'b0;
        por_n      = 1'b0;
        strap_mode = mode;
        strap_fsel = fsel;
        shared_in  = 4'hF;
        #100.3;
        // reset state: gated outputs low, pins not driven, oscillator kept on
        check(obs == '0, "R2 reset", "outputs low in reset", obs, 0);
        check(shared_oe == 4'h0, "R2 reset", "shared_oe in reset", shared_oe, 0);
        check(osc_en == 1'b1, "R6 reset", "osc_en in reset", osc_en, 1);
        por_n = 1'b1;
        #20;
        // move the strap pins: latched values must not follow
        strap_mode = ~mode;
        strap_fsel = ~fsel;
        #200;
        check(mode_q == mode, "R1", "mode_q", mode_q, mode);
        check(fsel_q == fsel, "R1", "fsel_q", fsel_q, fsel);
        meas_on = 1'b1;
    endtask

    logic done = 1'b0;

    initial begin
        void'($urandom(32'd20240611));

        // mobile mode, directed
        do_reset(1'b0, 3'd5);
        run_phase(4'hF, "all running");
        run_phase(4'hE, "cpu stop");
        run_phase(4'hF, "R3 cpu restart");
        run_phase(4'hD, "pci stop");
        run_phase(4'hB, "agp stop");
        run_phase(4'h8, "all stops");
        run_phase(4'h0, "R11 power-down with stops");
        run_phase(4'h7, "R11 stops released in power-down");
        run_phase(4'hF, "R8 wake");
        run_phase(4'h6, "R7 power-down from stops");
        run_phase(4'hE, "R8 wake to cpu stop");

        // mobile mode, random pins
        for (int k = 0; k < 12; k++) begin
            run_phase(4'($urandom_range(0, 15)), "R6 random mobile");
        end

        // desktop mode: shared pins ignored
        do_reset(1'b1, 3'($urandom_range(0, 7)));
        run_phase(4'h0, "R9 pins low");
        run_phase(4'h7, "R9 pd pin low");
        for (int k = 0; k < 6; k++) begin
            run_phase(4'($urandom_range(0, 15)), "R9 random desktop");
        end

        // back to mobile with another strap value
        do_reset(1'b0, 3'd2);
        run_phase(4'h5, "R7 power-down after reset");
        run_phase(4'hF, "R8 wake after reset");

        // no shortened high pulses seen on any observed output
        for (int i = 0; i < NOBS; i++) begin
            check(short_cnt[i] == 0, "R10", $sformatf("short pulses out%0d", i), short_cnt[i], 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #150000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule